// File: doc/BRIEF.md
# Configuration Readback Serial Streamer

The block turns a stored image, held as one word per frame in an external synchronous memory, into a single serial bit stream. A trigger level starts a readback. The block then raises its in-progress flag. On each following rising edge of the readback clock it puts one bit on the serial output. It adds all the fixed framing itself: a leading run of High filler bits, a Low start bit in front of each frame, four High check positions after each frame's payload, a closing Low start bit, and an 11-bit CRC signature taken over the payload bits as sent.

The serial line is a plain clocked pin with no handshake. The receiver samples one bit per clock while the flag is High and cannot apply back-pressure. Once a readback starts it runs to the end unless reset is applied. The memory port is a read-enable and address pair, and the word arrives one clock later. The block reads each frame's word exactly once, during the bit just before that frame's start bit. The frame count and the payload length are parameters, and the payload length must be at least 9.

Top module: `rbk_streamer`

## Requirements
- R1: With the block idle and armed, a High trigger sampled on a rising edge sets busy_o High after that same edge. The first stream bit appears after the following edge, and each later edge presents one more bit.
- R2: The stream opens with five High bits followed by a Low start bit for frame 0. Every later frame is also preceded by one Low start bit.
- R3: Payload bits of each frame are sent from the most significant bit of the word (bit FRAME_BITS-1) down to bit 0. In frame 0, the first two payload bits are sent as 1 whatever the memory holds.
- R4: Each frame's payload is followed by four bits sent as 1.
- R5: In the last frame, the final seven payload bits (word bits 6 down to 0) are sent as 1.
- R6: After the last frame's check bits, one Low start bit is sent, then the 11 CRC bits. busy_o falls on the edge after the last CRC bit, so it stays High for exactly 5 + N_FRAMES*(FRAME_BITS+5) + 12 bit periods after the first stream bit appears.
- R7: The CRC register starts at zero for each readback and updates once for each payload bit as sent (forced bits included), and for no other bit. Each update computes fb = crc[10] xor bit, shifts crc left by one, and xors CRC_POLY in when fb is 1. The CRC is sent most significant bit first.
- R8: The trigger is ignored while busy_o is High. A new readback starts only after the trigger has been seen Low while idle. This also holds after reset.
- R9: While idle, sdata_o is High.
- R10: For each frame f, mem_rd_en_o is High for exactly one cycle with mem_addr_o = f, in the bit period just before frame f's start bit. The frames are read in order 0 to N_FRAMES-1, and mem_rdata_i is taken one cycle later.
- R11: A synchronous active-high reset returns the block to idle at once: busy_o Low, sdata_o High, no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Readback trigger level |
| mem_rd_en_o | output | 1 | Frame memory read enable |
| mem_addr_o | output | FR_W | Frame index being read |
| mem_rdata_i | input | FRAME_BITS | Frame word, valid one cycle after the read |
| sdata_o | output | 1 | Serial readback data |
| busy_o | output | 1 | Readback in progress |

## Verification
Two events can fall in the same clock: the edge that ends a stream and drops the flag, and a trigger that is still held High. The bench keeps the trigger High through the whole run, and in one run pulses it Low and High again mid-stream. It then judges that the flag stays Low for several cycles after the stream ends. The fetch of the next frame's word also coincides with the last check bit of the previous frame. This is judged bit by bit against a bench model of the stream built from memory patterns (zeros, ones, alternating and counting words), which also catches a word taken one cycle early or late.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_DUMMY,
    PH_START,
    PH_DATA,
    PH_CHECK,
    PH_CLOSE,
    PH_SIG
  } phase_e;

  typedef enum logic [1:0] {
    BK_HIGH,
    BK_LOW,
    BK_PAY,
    BK_SIG
  } bitkind_e;

  localparam int DUMMY_LEN   = 5;
  localparam int CHECK_LEN   = 4;
  localparam int SIG_W       = 11;
  localparam int FIRST_FORCE = 2;
  localparam int LAST_FORCE  = 7;

  function automatic logic [SIG_W-1:0] sig_step(
    input logic [SIG_W-1:0] cur,
    input logic             din,
    input logic [SIG_W-1:0] poly
  );
    logic fb;
    fb = cur[SIG_W-1] ^ din;
    return {cur[SIG_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/rbk_seq.sv
module rbk_seq
  import rbk_pkg::*;
#(
  parameter int N_FRAMES   = 4,
  parameter int FRAME_BITS = 16,
  localparam int FR_W      = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1,
  localparam int MAXC      = (FRAME_BITS > SIG_W) ? FRAME_BITS : SIG_W,
  localparam int CNT_W     = $clog2(MAXC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [FR_W-1:0]  frame_o,
  output logic             busy_o,
  output bitkind_e         kind_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             clear_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             rd_en_o,
  output logic [FR_W-1:0]  rd_addr_o
);

  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CHECK_LAST = CNT_W'(CHECK_LEN - 1);
  localparam logic [CNT_W-1:0] SIG_LAST   = CNT_W'(SIG_W - 1);
  localparam logic [FR_W-1:0]  FRAME_LAST = FR_W'(N_FRAMES - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FR_W-1:0]  frame_q, frame_d;
  logic             armed_q, armed_d;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    frame_d   = frame_q;
    armed_d   = armed_q;
    kind_o    = BK_HIGH;
    idx_o     = '0;
    clear_o   = 1'b0;
    load_o    = 1'b0;
    shift_o   = 1'b0;
    rd_en_o   = 1'b0;
    rd_addr_o = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (!trig_i) begin
          armed_d = 1'b1;
        end else if (armed_q) begin
          armed_d = 1'b0;
          phase_d = PH_ARM;
          cnt_d   = '0;
          frame_d = '0;
          clear_o = 1'b1;
        end
      end
      PH_ARM: begin
        phase_d = PH_DUMMY;
        cnt_d   = '0;
      end
      PH_DUMMY: begin
        if (cnt_q == DUMMY_LAST) begin
          phase_d   = PH_START;
          frame_d   = '0;
          kind_o    = BK_LOW;
          rd_en_o   = 1'b1;
          rd_addr_o = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_START: begin
        phase_d = PH_DATA;
        cnt_d   = '0;
        kind_o  = BK_PAY;
        load_o  = 1'b1;
        idx_o   = '0;
      end
      PH_DATA: begin
        if (cnt_q == DATA_LAST) begin
          phase_d = PH_CHECK;
          cnt_d   = '0;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          kind_o  = BK_PAY;
          shift_o = 1'b1;
          idx_o   = cnt_q + 1'b1;
        end
      end
      PH_CHECK: begin
        if (cnt_q == CHECK_LAST) begin
          kind_o = BK_LOW;
          cnt_d  = '0;
          if (frame_q == FRAME_LAST) begin
            phase_d = PH_CLOSE;
          end else begin
            phase_d   = PH_START;
            frame_d   = frame_q + 1'b1;
            rd_en_o   = 1'b1;
            rd_addr_o = frame_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_CLOSE: begin
        phase_d = PH_SIG;
        cnt_d   = '0;
        kind_o  = BK_SIG;
      end
      PH_SIG: begin
        if (cnt_q == SIG_LAST) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          kind_o = BK_SIG;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      frame_q <= '0;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
      armed_q <= armed_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign frame_o = frame_q;
  assign busy_o  = (phase_q != PH_IDLE);

  // R1: the flag only rises after a High trigger was sampled
  p_start_needs_trig_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(trig_i));

  // R8: without a Low trigger seen while idle, no readback begins
  p_no_rearm_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !armed_q) |=> (phase_q == PH_IDLE));

  // R10: a word fetch is always followed by that frame's start bit
  p_fetch_then_start_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> (phase_q == PH_START && frame_q == $past(rd_addr_o)));

endmodule

// File: rtl/rbk_payload.sv
module rbk_payload
  import rbk_pkg::*;
#(
  parameter int N_FRAMES   = 4,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 5,
  localparam int FR_W      = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic [CNT_W-1:0]      idx_i,
  input  logic [FR_W-1:0]       frame_i,
  output logic                  bit_o
);

  logic [FRAME_BITS-1:0] sr_q;
  logic                  raw;
  logic                  force_first;
  logic                  force_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= {word_i[FRAME_BITS-2:0], 1'b0};
    end else if (shift_i) begin
      sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign raw         = load_i ? word_i[FRAME_BITS-1] : sr_q[FRAME_BITS-1];
  assign force_first = (frame_i == '0) && (int'(idx_i) < FIRST_FORCE);
  assign force_last  = (frame_i == FR_W'(N_FRAMES - 1)) &&
                       (int'(idx_i) >= FRAME_BITS - LAST_FORCE);
  assign bit_o       = raw | force_first | force_last;

  // R3: the shifter is never loaded and shifted in the same cycle
  p_load_shift_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(load_i && shift_i));

endmodule

// File: rtl/rbk_crc.sv
module rbk_crc
  import rbk_pkg::*;
#(
  parameter logic [SIG_W-1:0] CRC_POLY = 11'h385
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic step_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic msb_o
);

  logic [SIG_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      crc_q <= '0;
    end else if (step_i) begin
      crc_q <= sig_step(crc_q, bit_i, CRC_POLY);
    end else if (shift_i) begin
      crc_q <= {crc_q[SIG_W-2:0], 1'b0};
    end
  end

  assign msb_o = crc_q[SIG_W-1];

  // R7: accumulation and emission never overlap
  p_step_shift_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(step_i && shift_i));

endmodule

// File: rtl/rbk_streamer.sv
module rbk_streamer
  import rbk_pkg::*;
#(
  parameter int               N_FRAMES   = 4,
  parameter int               FRAME_BITS = 16,
  parameter logic [SIG_W-1:0] CRC_POLY   = 11'h385,
  localparam int              FR_W       = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1,
  localparam int              MAXC       = (FRAME_BITS > SIG_W) ? FRAME_BITS : SIG_W,
  localparam int              CNT_W      = $clog2(MAXC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig_i,
  output logic                  mem_rd_en_o,
  output logic [FR_W-1:0]       mem_addr_o,
  input  logic [FRAME_BITS-1:0] mem_rdata_i,
  output logic                  sdata_o,
  output logic                  busy_o
);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [FR_W-1:0]  frame;
  bitkind_e         kind;
  logic [CNT_W-1:0] idx;
  logic             clear, load, shift;
  logic             pay_bit, sig_bit;
  logic             dout_q, dout_d;

  rbk_seq #(
    .N_FRAMES  (N_FRAMES),
    .FRAME_BITS(FRAME_BITS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig_i),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .frame_o  (frame),
    .busy_o   (busy_o),
    .kind_o   (kind),
    .idx_o    (idx),
    .clear_o  (clear),
    .load_o   (load),
    .shift_o  (shift),
    .rd_en_o  (mem_rd_en_o),
    .rd_addr_o(mem_addr_o)
  );

  rbk_payload #(
    .N_FRAMES  (N_FRAMES),
    .FRAME_BITS(FRAME_BITS),
    .CNT_W     (CNT_W)
  ) u_payload (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .shift_i(shift),
    .word_i (mem_rdata_i),
    .idx_i  (idx),
    .frame_i(frame),
    .bit_o  (pay_bit)
  );

  rbk_crc #(
    .CRC_POLY(CRC_POLY)
  ) u_crc (
    .clk    (clk),
    .rst    (rst),
    .clear_i(clear),
    .step_i (kind == BK_PAY),
    .bit_i  (pay_bit),
    .shift_i(kind == BK_SIG),
    .msb_o  (sig_bit)
  );

  always_comb begin
    unique case (kind)
      BK_HIGH: dout_d = 1'b1;
      BK_LOW:  dout_d = 1'b0;
      BK_PAY:  dout_d = pay_bit;
      BK_SIG:  dout_d = sig_bit;
      default: dout_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= 1'b1;
    else     dout_q <= dout_d;
  end

  assign sdata_o = dout_q;

  // R2: filler bits are High and each start bit is Low
  p_dummy_high_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DUMMY || phase == PH_ARM) |-> sdata_o);
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_START) |-> !sdata_o);

  // R3: leading payload bits of frame 0 are High
  p_first_forced_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && frame == '0 && int'(cnt) < FIRST_FORCE) |-> sdata_o);

  // R4: check positions are High
  p_check_high_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CHECK) |-> sdata_o);

  // R5: trailing payload bits of the last frame are High
  p_last_forced_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && frame == FR_W'(N_FRAMES - 1) &&
     int'(cnt) >= FRAME_BITS - LAST_FORCE) |-> sdata_o);

  // R6: the closing start bit is Low
  p_close_low_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CLOSE) |-> !sdata_o);

  // R9: the line rests High while idle
  p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> sdata_o);

  // R11: the cycle after reset is idle
  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (!busy_o && sdata_o && !mem_rd_en_o));

endmodule

// File: tb/rbk_streamer_bench.sv
module rbk_streamer_bench;

  localparam int NF    = 3;
  localparam int FB    = 12;
  localparam logic [10:0] POLY = 11'h385;
  localparam int FR_W  = 2;
  localparam int SLEN  = 5 + NF * (FB + 5) + 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            trig = 1'b0;
  logic            rd_en;
  logic [FR_W-1:0] rd_addr;
  logic [FB-1:0]   rdata = '0;
  logic            sdata, busy;

  logic [FB-1:0]   mem [NF];
  int              rd_cnt = 0;
  int              rd_bad = 0;
  int              exp_addr = 0;

  int     n_chk = 0;
  int     n_err = 0;
  bit     done  = 1'b0;
  bit     exp_bits [SLEN];
  string  exp_tag  [SLEN];

  always #10 clk = ~clk;

  rbk_streamer #(
    .N_FRAMES  (NF),
    .FRAME_BITS(FB),
    .CRC_POLY  (POLY)
  ) u_rbk_streamer (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig),
    .mem_rd_en_o(rd_en),
    .mem_addr_o (rd_addr),
    .mem_rdata_i(rdata),
    .sdata_o    (sdata),
    .busy_o     (busy)
  );

  // memory model with one-cycle latency; logs read order (R10)
  always @(posedge clk) begin
    if (rst) begin
      exp_addr <= 0;
    end else if (rd_en) begin
      rdata  <= mem[rd_addr];
      rd_cnt <= rd_cnt + 1;
      if (int'(rd_addr) != exp_addr) rd_bad <= rd_bad + 1;
      exp_addr <= (exp_addr == NF - 1) ? 0 : exp_addr + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic build_exp();
    logic [10:0] crc;
    int pos;
    bit b;
    bit fb;
    crc = '0;
    pos = 0;
    for (int k = 0; k < 5; k++) begin
      exp_bits[pos] = 1'b1; exp_tag[pos] = "R2"; pos++;
    end
    for (int f = 0; f < NF; f++) begin
      exp_bits[pos] = 1'b0; exp_tag[pos] = "R2"; pos++;
      for (int j = 0; j < FB; j++) begin
        b = mem[f][FB-1-j];
        exp_tag[pos] = "R3";
        if (f == 0 && j < 2) b = 1'b1;
        if (f == NF - 1 && j >= FB - 7) begin
          b = 1'b1; exp_tag[pos] = "R5";
        end
        fb  = crc[10] ^ b;
        crc = {crc[9:0], 1'b0};
        if (fb) crc = crc ^ POLY;
        exp_bits[pos] = b; pos++;
      end
      for (int k = 0; k < 4; k++) begin
        exp_bits[pos] = 1'b1; exp_tag[pos] = "R4"; pos++;
      end
    end
    exp_bits[pos] = 1'b0; exp_tag[pos] = "R6"; pos++;
    for (int k = 10; k >= 0; k--) begin
      exp_bits[pos] = crc[k]; exp_tag[pos] = "R7"; pos++;
    end
  endtask

  task automatic do_run(input bit toggle_mid);
    int rd_base;
    int bad_base;
    build_exp();
    rd_base  = rd_cnt;
    bad_base = rd_bad;
    @(negedge clk);
    chk(!busy, "R1", "busy before start", int'(busy), 0);
    trig = 1'b1;
    @(negedge clk);
    chk(busy, "R1", "busy after trigger edge", int'(busy), 1);
    for (int i = 0; i < SLEN; i++) begin
      @(negedge clk);
      if (toggle_mid && i == 20) trig = 1'b0;
      if (toggle_mid && i == 30) trig = 1'b1;
      chk(busy && (sdata == exp_bits[i]), exp_tag[i], $sformatf("bit %0d", i),
          int'({busy, sdata}), int'({1'b1, exp_bits[i]}));
    end
    @(negedge clk);
    chk(!busy, "R6", "busy after last CRC bit", int'(busy), 0);
    chk(sdata, "R9", "idle line", int'(sdata), 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!busy, "R8", "held trigger ignored", int'(busy), 0);
    end
    trig = 1'b0;
    @(negedge clk);
    chk(rd_cnt - rd_base == NF, "R10", "reads per run", rd_cnt - rd_base, NF);
    chk(rd_bad == bad_base, "R10", "read order errors", rd_bad - bad_base, 0);
  endtask

  initial begin
    for (int f = 0; f < NF; f++) mem[f] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && sdata && !rd_en, "R11", "reset state",
        int'({busy, sdata, rd_en}), 2);
    // trigger already High at reset release must not start (R8)
    trig = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!busy, "R8", "no start without low trigger", int'(busy), 0);
    end
    trig = 1'b0;
    @(negedge clk);

    do_run(1'b0);                                 // all zeros
    for (int f = 0; f < NF; f++) mem[f] = '1;
    do_run(1'b1);                                 // all ones, trigger pulsed mid-run
    for (int f = 0; f < NF; f++) mem[f] = (f % 2 == 0) ? 12'hA5A : 12'h5A5;
    do_run(1'b0);
    for (int f = 0; f < NF; f++) mem[f] = FB'(12'h123 * (f + 1) + 12'h0F0);
    do_run(1'b1);
    for (int p = 0; p < 4; p++) begin              // walking one sweep
      for (int f = 0; f < NF; f++) mem[f] = FB'(1) << ((p * 3 + f) % FB);
      do_run(1'b0);
    end

    // reset in mid-stream (R11)
    @(negedge clk);
    trig = 1'b1;
    repeat (30) @(negedge clk);
    chk(busy, "R11", "busy before reset", int'(busy), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && sdata && !rd_en, "R11", "reset mid-stream",
        int'({busy, sdata, rd_en}), 2);
    trig = 1'b0;
    rst  = 1'b0;
    @(negedge clk);
    for (int f = 0; f < NF; f++) mem[f] = 12'hC3C;
    do_run(1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule